// File: doc/BRIEF.md
# I2C Controller Interrupt Status and Clear Unit

This unit gathers the twelve event sources of an I2C controller into one raw status word. Ten sources are sticky. A one-cycle pulse sets the bit and the bit stays set until software clears it. The RX-full and TX-empty sources are levels that follow the FIFO threshold logic. A programmable enable mask selects which raw bits appear in the masked status word. The OR of the masked bits drives a single interrupt line.

Software reaches the unit through a simple register port: an address, a read strobe, a write strobe and write data. Read data is combinational and shows the value from before the edge. Every source has its own read-to-clear register, and one further register clears all sticky bits at once. When the TX-abort event pulses, the unit also latches a word that gives the abort reason. Only a read of the TX-abort clear register empties that word, so software must read the reason before it clears the event.

Register word addresses (`reg_addr`, 5 bits):
- 0x00: raw status.
- 0x01: mask, read/write, 12 bits.
- 0x02: masked status.
- 0x03: clear-all. The read returns the raw status.
- 0x04: abort reason.
- 0x05: bit 0 is bus activity.
- 0x10+i: clear register for source i. The read returns the raw bit i in bit 0.

Top module: `evt_irq_ctrl`

## Requirements
- R1: Sticky source bit positions: 0 RX-under, 1 RX-over, 3 TX-over, 5 read-request, 6 TX-abort, 7 RX-done, 8 activity, 9 stop-detect, 10 start-detect, 11 general-call. A pulse on `evt_in[i]` for one of these sets raw bit i at the next edge, and the bit stays set until it is cleared.
- R2: Raw bits 2 (RX-full) and 4 (TX-empty) equal `evt_in` from the previous cycle. Clear reads have no effect on them.
- R3: A read of address 0x10+i clears only sticky bit i. The read returns that bit's value from before the clear in bit 0 of the read data.
- R4: A read of address 0x03 returns the raw status and clears every sticky bit.
- R5: If a source pulses in the same cycle as a read of its clear register (0x10+i or 0x03), the bit ends up set.
- R6: A write to 0x01 loads the mask from `reg_wdata[11:0]`, and a read of 0x01 returns it. Address 0x02 always reads as raw AND mask.
- R7: `irq` is high exactly when some bit of raw AND mask is set. It changes in the cycle after the edge that changes the raw status or the mask.
- R8: While `evt_in[6]` pulses, `abort_reason` is ORed into the abort word. The stored reason bits are:
  - 0: 7-bit address not acknowledged.
  - 1 and 2: first and second 10-bit address bytes not acknowledged.
  - 3: data not acknowledged.
  - 4: general call not acknowledged.
  - 5: read after general call.
  - 7: start byte acknowledged.
  - 9: start byte with restart disabled.
  - 10: 10-bit read with restart disabled.
  - 11: use while disabled.
  - 12: arbitration lost.
  Bits 6 and 8 are never stored. The word reads at 0x04.
- R9: Only a read of 0x16 (the TX-abort clear register) empties the abort word. The clear-all read leaves the word unchanged. If a TX-abort pulse arrives in the same cycle as the 0x16 read, the word holds exactly the new reason.
- R10: A read of 0x05 returns `bus_active` in bit 0, with the upper bits at zero.
- R11: After a synchronous active-low reset, the raw status, the mask, the abort word and `irq` are all zero.
- R12: Reads of unmapped addresses return zero. Writes to any address other than 0x01 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_in | input | 12 | Event pulses on the sticky bits; levels on bits 2 and 4 |
| abort_reason | input | 13 | Abort reason bits, taken while `evt_in[6]` is high |
| bus_active | input | 1 | Bus activity level from the controller |
| reg_addr | input | 5 | Register word address |
| reg_rd | input | 1 | Read strobe; reads with side effects act on it |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational, zero when `reg_rd` is low |
| irq | output | 1 | Interrupt request |

## Verification
Each state error has its own visible symptom. A latch that fails to set or fails to clear makes the raw status and `irq` disagree with the model on the very next read or the next cycle. A mask error shows at once in the masked register and the interrupt line. Loss of the set-wins priority, or an abort word that the wrong register clears, shows at the first read after the colliding cycle. Random event, read and write traffic keeps the model and the ports compared cycle by cycle, so a corrupted bit is seen within a few cycles.

// File: rtl/evt_irq_pkg.sv
// Package: shared register map and source indices for the interrupt status unit.
// Assumes word addressing; clear registers sit in the upper half of the map.
package evt_irq_pkg;
    localparam int A_RAW    = 0;
    localparam int A_MASK   = 1;
    localparam int A_MASKED = 2;
    localparam int A_CLRALL = 3;
    localparam int A_ABORT  = 4;
    localparam int A_ACTIV  = 5;

    typedef enum int {
        SRC_RX_UNDER = 0, SRC_RX_OVER = 1, SRC_RX_FULL = 2, SRC_TX_OVER = 3,
        SRC_TX_EMPTY = 4, SRC_RD_REQ = 5, SRC_TX_ABORT = 6, SRC_RX_DONE = 7,
        SRC_ACTIVITY = 8, SRC_STOP = 9, SRC_START = 10, SRC_GCALL = 11
    } src_idx_e;
endpackage

// File: rtl/evt_latch_bank.sv
// Module: per-source status latches. Bits flagged in LEVEL_MASK register the
// input level; all others are sticky, set by a pulse, cleared by a clear strobe.
// Assumes clear strobes are single-cycle; a set in the same cycle wins.
module evt_latch_bank #(
    parameter int              NUM_SRC    = 12,
    parameter logic [NUM_SRC-1:0] LEVEL_MASK = 12'h014
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_in,
    input  logic [NUM_SRC-1:0] clr_one,
    input  logic               clr_all,
    output logic [NUM_SRC-1:0] raw_q
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        logic bit_q;
        if (LEVEL_MASK[i]) begin : g_level
            // Level source: follow the threshold input one cycle later.
            always_ff @(posedge clk) begin
                if (!rst_n) bit_q <= 1'b0;
                else        bit_q <= evt_in[i];
            end
        end else begin : g_sticky
            // Sticky source: set on pulse, clear on strobe, set has priority.
            always_ff @(posedge clk) begin
                if (!rst_n)                    bit_q <= 1'b0;
                else if (evt_in[i])            bit_q <= 1'b1;
                else if (clr_one[i] || clr_all) bit_q <= 1'b0;
            end
        end
        assign raw_q[i] = bit_q;
    end
endmodule

// File: rtl/abort_capture.sv
// Module: accumulates abort reason bits while the abort event pulses and
// empties the word on the abort clear strobe. Reserved bits are never stored.
module abort_capture #(
    parameter int              ABRT_W    = 13,
    parameter logic [ABRT_W-1:0] ABRT_KEEP = 13'h1EBF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort_evt,
    input  logic [ABRT_W-1:0] reason_in,
    input  logic              clr,
    output logic [ABRT_W-1:0] word_q
);
    // Capture: new reason ORs in; a simultaneous clear drops only the old bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            word_q <= '0;
        else if (abort_evt)
            word_q <= (clr ? '0 : word_q) | (reason_in & ABRT_KEEP);
        else if (clr)
            word_q <= '0;
    end
endmodule

// File: rtl/reg_decode.sv
// Module: register port decode. Holds the mask register, forms read data
// combinationally and raises clear strobes on reads with side effects.
// Assumes NUM_SRC fits in the clear half of the address map.
module reg_decode
    import evt_irq_pkg::*;
#(
    parameter int NUM_SRC   = 12,
    parameter int ADDR_W    = 5,
    parameter int DATA_W    = 16,
    parameter int ABRT_W    = 13,
    parameter int ABORT_BIT = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_rd,
    input  logic               reg_wr,
    input  logic [DATA_W-1:0]  reg_wdata,
    input  logic [NUM_SRC-1:0] raw_q,
    input  logic [ABRT_W-1:0]  abort_q,
    input  logic               bus_active,
    output logic [NUM_SRC-1:0] mask_q,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic [NUM_SRC-1:0] clr_one,
    output logic               clr_all,
    output logic               clr_abort
);
    localparam int IDX_W = ADDR_W - 1;

    logic             in_clr;
    logic [IDX_W-1:0] idx;
    logic             idx_ok;

    assign in_clr = reg_addr[ADDR_W-1];
    assign idx    = reg_addr[IDX_W-1:0];
    assign idx_ok = (32'(idx) < NUM_SRC);

    // Mask register: loaded only by a write to its own address.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (reg_wr && reg_addr == ADDR_W'(A_MASK))
            mask_q <= reg_wdata[NUM_SRC-1:0];
    end

    // Clear strobes: one-hot per-source clear, clear-all and abort clear.
    always_comb begin
        clr_one = '0;
        if (reg_rd && in_clr && idx_ok)
            clr_one = NUM_SRC'(1) << idx;
    end
    assign clr_all   = reg_rd && (reg_addr == ADDR_W'(A_CLRALL));
    assign clr_abort = clr_one[ABORT_BIT];

    // Read mux: value before the edge, zero when not reading.
    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            if (in_clr) begin
                if (idx_ok) reg_rdata = DATA_W'(raw_q[idx]);
            end else begin
                case (reg_addr)
                    ADDR_W'(A_RAW):    reg_rdata = DATA_W'(raw_q);
                    ADDR_W'(A_MASK):   reg_rdata = DATA_W'(mask_q);
                    ADDR_W'(A_MASKED): reg_rdata = DATA_W'(raw_q & mask_q);
                    ADDR_W'(A_CLRALL): reg_rdata = DATA_W'(raw_q);
                    ADDR_W'(A_ABORT):  reg_rdata = DATA_W'(abort_q);
                    ADDR_W'(A_ACTIV):  reg_rdata = DATA_W'(bus_active);
                    default:           reg_rdata = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/evt_irq_ctrl.sv
// Module: top of the interrupt status unit. Latches events, applies the mask,
// drives the interrupt line and captures the abort reason word.
// Assumes events arrive as one-cycle pulses, except the level sources.
module evt_irq_ctrl #(
    parameter int NUM_SRC   = 12,
    parameter int ADDR_W    = 5,
    parameter int DATA_W    = 16,
    parameter int ABRT_W    = 13,
    parameter int ABORT_BIT = 6,
    parameter logic [NUM_SRC-1:0] LEVEL_MASK = 12'h014,
    parameter logic [ABRT_W-1:0]  ABRT_KEEP  = 13'h1EBF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] evt_in,
    input  logic [ABRT_W-1:0]  abort_reason,
    input  logic               bus_active,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_rd,
    input  logic               reg_wr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    output logic               irq
);
    logic [NUM_SRC-1:0] raw_q;
    logic [NUM_SRC-1:0] mask_q;
    logic [ABRT_W-1:0]  abort_q;
    logic [NUM_SRC-1:0] clr_one;
    logic               clr_all;
    logic               clr_abort;

    evt_latch_bank #(.NUM_SRC(NUM_SRC), .LEVEL_MASK(LEVEL_MASK)) u_bank (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .clr_one(clr_one),
        .clr_all(clr_all), .raw_q(raw_q)
    );

    abort_capture #(.ABRT_W(ABRT_W), .ABRT_KEEP(ABRT_KEEP)) u_abort (
        .clk(clk), .rst_n(rst_n), .abort_evt(evt_in[ABORT_BIT]),
        .reason_in(abort_reason), .clr(clr_abort), .word_q(abort_q)
    );

    reg_decode #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
                 .ABRT_W(ABRT_W), .ABORT_BIT(ABORT_BIT)) u_dec (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .raw_q(raw_q), .abort_q(abort_q),
        .bus_active(bus_active), .mask_q(mask_q), .reg_rdata(reg_rdata),
        .clr_one(clr_one), .clr_all(clr_all), .clr_abort(clr_abort)
    );

    // Interrupt line: any enabled status bit.
    assign irq = |(raw_q & mask_q);
endmodule

// File: rtl/evt_irq_ctrl_chk.sv
// Checker: temporal properties of the interrupt status unit, bound to the top.
module evt_irq_ctrl_chk #(
    parameter int NUM_SRC   = 12,
    parameter int ADDR_W    = 5,
    parameter int DATA_W    = 16,
    parameter int ABRT_W    = 13,
    parameter int ABORT_BIT = 6,
    parameter logic [NUM_SRC-1:0] LEVEL_MASK = 12'h014,
    parameter logic [ABRT_W-1:0]  ABRT_KEEP  = 13'h1EBF
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] evt_in,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic               reg_rd,
    input logic [DATA_W-1:0]  reg_rdata,
    input logic               irq,
    input logic [NUM_SRC-1:0] raw_q,
    input logic [NUM_SRC-1:0] mask_q,
    input logic [ABRT_W-1:0]  abort_q
);
    localparam logic [NUM_SRC-1:0] STICKY = ~LEVEL_MASK;
    localparam int CLR_BASE = 1 << (ADDR_W - 1);

    assert_sticky_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_in & STICKY) != '0 |=> (raw_q & $past(evt_in & STICKY)) == $past(evt_in & STICKY));

    assert_level_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (raw_q & LEVEL_MASK) == ($past(evt_in) & LEVEL_MASK));

    assert_clear_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd && reg_addr == ADDR_W'(CLR_BASE) && !evt_in[0] |=> !raw_q[0]);

    assert_clear_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd && reg_addr == ADDR_W'(3) && evt_in == '0 |=> (raw_q & STICKY) == '0);

    assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd && reg_addr == ADDR_W'(CLR_BASE) && evt_in[0] |=> raw_q[0]);

    assert_masked_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd && reg_addr == ADDR_W'(2) |-> reg_rdata == DATA_W'(raw_q & mask_q));

    assert_irq_enabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> mask_q != '0 && raw_q != '0);

    assert_abort_reserved_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_q & ~ABRT_KEEP) == '0);

    assert_abort_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd && reg_addr == ADDR_W'(CLR_BASE + ABORT_BIT) && !evt_in[ABORT_BIT]
        |=> abort_q == '0);
endmodule

bind evt_irq_ctrl evt_irq_ctrl_chk #(
    .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ABRT_W(ABRT_W),
    .ABORT_BIT(ABORT_BIT), .LEVEL_MASK(LEVEL_MASK), .ABRT_KEEP(ABRT_KEEP)
) u_chk (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .reg_addr(reg_addr),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata), .irq(irq), .raw_q(raw_q),
    .mask_q(mask_q), .abort_q(abort_q)
);

// File: tb/evt_irq_ctrl_bench.sv
`timescale 1ns/1ps
module evt_irq_ctrl_bench;
    localparam logic [11:0] LVL  = 12'h014;
    localparam logic [12:0] KEEP = 13'h1EBF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] evt_in = '0;
    logic [12:0] abort_reason = '0;
    logic        bus_active = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic        reg_rd = 1'b0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [11:0] m_raw = '0;
    logic [11:0] m_mask = '0;
    logic [12:0] m_abort = '0;

    always #2.5 clk = ~clk;

    evt_irq_ctrl u_evt_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .abort_reason(abort_reason),
        .bus_active(bus_active), .reg_addr(reg_addr), .reg_rd(reg_rd),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    function automatic logic [15:0] exp_read(input logic [4:0] a, input logic act);
        if (a[4]) return (a[3:0] < 12) ? 16'(m_raw[a[3:0]]) : 16'h0;
        case (a)
            5'h00, 5'h03: return 16'(m_raw);
            5'h01: return 16'(m_mask);
            5'h02: return 16'(m_raw & m_mask);
            5'h04: return 16'(m_abort);
            5'h05: return 16'(act);
            default: return 16'h0;
        endcase
    endfunction

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // One cycle: drive away from the edge, check reads and irq, then advance the model.
    task automatic step(input logic [11:0] ev, input logic [4:0] a, input logic rd,
                        input logic wr, input logic [15:0] wd, input logic [12:0] rs,
                        input logic act, input string req);
        logic clr6;
        @(negedge clk);
        evt_in = ev; reg_addr = a; reg_rd = rd; reg_wr = wr; reg_wdata = wd;
        abort_reason = rs; bus_active = act;
        #1;
        if (rd) check(req, reg_rdata, exp_read(a, act));
        check("R7", 16'(irq), 16'(|(m_raw & m_mask)));
        @(posedge clk);
        clr6 = rd && a == 5'h16;
        for (int i = 0; i < 12; i++) begin
            if (LVL[i]) m_raw[i] = ev[i];
            else if (ev[i]) m_raw[i] = 1'b1;
            else if (rd && (a == 5'h03 || (a[4] && a[3:0] == 4'(i)))) m_raw[i] = 1'b0;
        end
        if (ev[6]) m_abort = (clr6 ? 13'h0 : m_abort) | (rs & KEEP);
        else if (clr6) m_abort = '0;
        if (wr && a == 5'h01) m_mask = wd[11:0];
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step('0, '0, 1'b0, 1'b0, '0, '0, 1'b0, "R7");
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog got=timeout exp=completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R11: reset state
        step('0, 5'h00, 1, 0, '0, '0, 0, "R11");
        step('0, 5'h01, 1, 0, '0, '0, 0, "R11");
        step('0, 5'h04, 1, 0, '0, '0, 0, "R11");
        check("R11", 16'(irq), 16'h0);

        // R1: sticky bits latch and hold
        step(12'h0A9, '0, 0, 0, '0, '0, 0, "R1");
        idle(3);
        step('0, 5'h00, 1, 0, '0, '0, 0, "R1");
        // R3: clear only source 0
        step('0, 5'h10, 1, 0, '0, '0, 0, "R3");
        step('0, 5'h00, 1, 0, '0, '0, 0, "R3");
        // R5: set wins over own clear, and over clear-all
        step(12'h080, 5'h17, 1, 0, '0, '0, 0, "R5");
        step('0, 5'h00, 1, 0, '0, '0, 0, "R5");
        step(12'h200, 5'h03, 1, 0, '0, '0, 0, "R5");
        step('0, 5'h00, 1, 0, '0, '0, 0, "R5");
        // R4: clear-all
        step('0, 5'h03, 1, 0, '0, '0, 0, "R4");
        step('0, 5'h00, 1, 0, '0, '0, 0, "R4");
        // R2: levels follow, clear reads do not touch them
        step(12'h014, '0, 0, 0, '0, '0, 0, "R2");
        step(12'h014, 5'h12, 1, 0, '0, '0, 0, "R2");
        step(12'h014, 5'h03, 1, 0, '0, '0, 0, "R2");
        step(12'h010, 5'h00, 1, 0, '0, '0, 0, "R2");
        step('0, 5'h00, 1, 0, '0, '0, 0, "R2");
        // R6/R7: mask write, readback, masked view and irq
        step('0, 5'h01, 0, 1, 16'hFFFF, '0, 0, "R6");
        step('0, 5'h01, 1, 0, '0, '0, 0, "R6");
        step(12'h008, 5'h02, 1, 0, '0, '0, 0, "R6");
        step('0, 5'h02, 1, 0, '0, '0, 0, "R7");
        step('0, 5'h01, 0, 1, 16'h0004, '0, 0, "R7");
        step('0, 5'h02, 1, 0, '0, '0, 0, "R7");
        // R8: abort accumulation, reserved bits dropped
        step(12'h040, '0, 0, 0, '0, 13'h0141, 0, "R8");
        step(12'h040, '0, 0, 0, '0, 13'h1008, 0, "R8");
        step('0, 5'h04, 1, 0, '0, '0, 0, "R8");
        // R9: clear-all keeps the word; abort clear empties it; collision loads new
        step('0, 5'h03, 1, 0, '0, '0, 0, "R9");
        step('0, 5'h04, 1, 0, '0, '0, 0, "R9");
        step(12'h040, 5'h16, 1, 0, '0, 13'h0800, 0, "R9");
        step('0, 5'h04, 1, 0, '0, '0, 0, "R9");
        step('0, 5'h16, 1, 0, '0, '0, 0, "R9");
        step('0, 5'h04, 1, 0, '0, '0, 0, "R9");
        // R10: activity status
        step('0, 5'h05, 1, 0, '0, '0, 1, "R10");
        step('0, 5'h05, 1, 0, '0, '0, 0, "R10");
        // R12: unmapped reads, writes elsewhere ignored
        step('0, 5'h07, 1, 0, '0, '0, 1, "R12");
        step('0, 5'h1D, 1, 0, '0, '0, 1, "R12");
        step('0, 5'h00, 0, 1, 16'hFFFF, '0, 0, "R12");
        step('0, 5'h04, 0, 1, 16'hFFFF, '0, 0, "R12");
        step('0, 5'h00, 1, 0, '0, '0, 0, "R12");
        step('0, 5'h04, 1, 0, '0, '0, 0, "R12");
        step('0, 5'h01, 1, 0, '0, '0, 0, "R12");

        // Random traffic: sparse events, mixed reads and mask writes.
        for (int n = 0; n < 4000; n++) begin
            logic [11:0] ev;
            ev = 12'($urandom) & 12'($urandom) & 12'($urandom);
            step(ev, 5'($urandom), 1'($urandom_range(0, 3) != 0),
                 1'($urandom_range(0, 7) == 0), 16'($urandom), 13'($urandom),
                 1'($urandom), "R1..R12 random");
        end
        finish_run();
    end
endmodule